// File: doc/BRIEF.md
# Edge-Qualified Timer Counter with Selectable Clearing

This block is one channel of a timer. It holds an up-counter that advances by one for each qualifying edge of a count source. The source is either an internal prescaled clock or an external pin, and the `src_ext` flag says which one is connected. The source is sampled into the system clock domain. The two-bit edge field picks which transitions count. The same code means opposite polarities for internal and external sources.

Four compare registers, A to D, are checked against the counter on every count event. A three-bit clear field picks what resets the counter:

- a compare hit on one chosen register, or
- a clear pulse from another channel of a synchronized group, or
- nothing.

Registers C and D may be placed in buffer mode. In buffer mode they never produce a hit, so a clear selected on them never happens.

The `FULL` parameter set to 0 builds a reduced variant. That variant has only registers A and B. It treats every clear code with its top bit set as "no clearing".

When a channel clears on its own hit, it raises `sync_clr_out` for one cycle. Any channel wired to that pulse can then clear on the same clock edge.

Top module: `tmr_chan`

## Requirements
- R1: With `rst` high at a clock edge, the counter goes to 0, all four match flags go to 0 and `sync_clr_out` stays 0.
- R2: For an internal source (`src_ext`=0), edge code 00 counts falling edges, 01 counts rising edges, and 10 or 11 counts both. The counter output changes on the third rising clock edge after the source changes.
- R3: For an external source (`src_ext`=1), the polarity is reversed. Edge code 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both.
- R4: With clear code 000 or 100, the counter never clears. It wraps from all-ones to 0.
- R5: Clear code 001 clears on register A. On the count event where the count equals A, the counter goes to 0 instead of incrementing, so the cycle length is A+1 events.
- R6: Clear code 010 clears on register B in the same way.
- R7: In the full variant, clear code 101 clears on register C and code 110 clears on register D.
- R8: In buffer mode (`buf_c` or `buf_d` high), register C or D produces no match flag and no clear. The counter keeps incrementing past that value.
- R9: With clear code 011 or 111 and `sync_en` high, the counter goes to 0 at the clock edge that ends a cycle in which `sync_clr_in` is high. With `sync_en` low, `sync_clr_in` has no effect.
- R10: `sync_clr_out` is high for exactly one cycle for each clear caused by the channel's own compare hit. The counter is 0 after the following edge, and a receiving channel (R9) clears at that same edge.
- R11: In the reduced variant (`FULL`=0), clear codes 100 to 111 never clear the counter, and match bits 2 and 3 stay 0.
- R12: Bit i of `match` (0=A, 1=B, 2=C, 3=D) is a one-cycle pulse. It is raised at the count event where the count equals register i, whatever the clear code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_src | input | 1 | Raw count source level |
| src_ext | input | 1 | 1 = external source, 0 = internal prescaled clock |
| edge_sel | input | 2 | Counting edge select |
| clr_sel | input | 3 | Clear source select |
| sync_en | input | 1 | Allows clearing by the synchronized group |
| buf_c | input | 1 | Register C in buffer mode |
| buf_d | input | 1 | Register D in buffer mode |
| reg_a | input | W | Compare register A |
| reg_b | input | W | Compare register B |
| reg_c | input | W | Compare register C |
| reg_d | input | W | Compare register D |
| sync_clr_in | input | 1 | Clear pulse from the group |
| count | output | W | Counter value |
| match | output | 4 | Compare hit pulses, bit 0 = A to bit 3 = D |
| sync_clr_out | output | 1 | One-cycle pulse on a clear caused by the channel's own hit |

## Verification
A wrong synchronizer tap or a wrong edge polarity shows up as a count that moves on the wrong transition of the source. It can also show as a count that moves one cycle early or late, and this is visible within four clocks of a single source edge. A wrong clear decode shows up at the first register hit: the counter steps past the compare value instead of returning to 0. A missing buffer-mode mask shows up the other way, as a return to 0 where the count should continue. Faults in the group clear are seen by pairing two channels: the receiver must read 0 at the same sample at which the sender does.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W    = 16,
  parameter bit FULL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_src,
  input  logic         src_ext,
  input  logic [1:0]   edge_sel,
  input  logic [2:0]   clr_sel,
  input  logic         sync_en,
  input  logic         buf_c,
  input  logic         buf_d,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  input  logic [W-1:0] reg_c,
  input  logic [W-1:0] reg_d,
  input  logic         sync_clr_in,
  output logic [W-1:0] count,
  output logic [3:0]   match,
  output logic         sync_clr_out
);
  logic [2:0] smp;
  logic [3:0] hit;
  logic [2:0] code;
  logic       own_hit;

  always_ff @(posedge clk)
    if (rst) smp <= '0;
    else     smp <= {smp[1:0], cnt_src};

  wire rise      = smp[1] & ~smp[2];
  wire fall      = ~smp[1] & smp[2];
  wire pick_rise = edge_sel[0] ^ src_ext;
  wire tick      = edge_sel[1] ? (rise | fall) : (pick_rise ? rise : fall);

  assign hit[0] = (count == reg_a);
  assign hit[1] = (count == reg_b);

  generate
    if (FULL) begin : g_full
      assign hit[2] = (count == reg_c) & ~buf_c;
      assign hit[3] = (count == reg_d) & ~buf_d;
      assign code   = clr_sel;
    end else begin : g_red
      assign hit[3:2] = 2'b00;
      assign code     = clr_sel[2] ? 3'b000 : clr_sel;
    end
  endgenerate

  always_comb
    case (code)
      3'b001:  own_hit = hit[0];
      3'b010:  own_hit = hit[1];
      3'b101:  own_hit = hit[2];
      3'b110:  own_hit = hit[3];
      default: own_hit = 1'b0;
    endcase

  wire sync_mode = (code[1:0] == 2'b11) & sync_en;
  assign sync_clr_out = tick & own_hit;

  always_ff @(posedge clk)
    if (rst) begin
      count <= '0;
      match <= '0;
    end else begin
      match <= tick ? hit : 4'b0000;
      if ((sync_mode & sync_clr_in) | sync_clr_out) count <= '0;
      else if (tick)                                 count <= count + 1'b1;
    end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0) && (match == 4'b0000));

  assert_no_clear_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && code[1:0] == 2'b00) |=> count == $past(count + 1'b1));

  assert_buffer_c_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    buf_c |=> !match[2]);

  assert_buffer_d_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    buf_d |=> !match[3]);

  assert_group_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && sync_clr_in) |=> count == '0);

  assert_own_clear_R10: assert property (@(posedge clk) disable iff (rst)
    sync_clr_out |=> count == '0);

  assert_match_after_event_R12: assert property (@(posedge clk) disable iff (rst)
    (match != 4'b0000) |-> $past(tick));
endmodule

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst = 1, src = 0, ext = 0;
  logic [1:0] esel = 2'b10;
  logic [2:0] c0 = 3'b000, c1 = 3'b000;
  logic sen1 = 0, bc = 0, bd = 0;
  logic [W-1:0] a0 = 8'd200, b0 = 8'd200, cc0 = 8'd200, d0 = 8'd200;
  logic [W-1:0] a1 = 8'd250, b1 = 8'd250, cc1 = 8'd250, d1 = 8'd250;
  logic [W-1:0] cnt0, cnt1;
  logic [3:0] m0, m1, seen0, seen1;
  logic so0, so1;
  int pulses, checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chan #(.W(W), .FULL(1'b1)) u0 (
    .clk(clk), .rst(rst), .cnt_src(src), .src_ext(ext), .edge_sel(esel),
    .clr_sel(c0), .sync_en(1'b0), .buf_c(bc), .buf_d(bd),
    .reg_a(a0), .reg_b(b0), .reg_c(cc0), .reg_d(d0), .sync_clr_in(1'b0),
    .count(cnt0), .match(m0), .sync_clr_out(so0));

  tmr_chan #(.W(W), .FULL(1'b0)) u1 (
    .clk(clk), .rst(rst), .cnt_src(src), .src_ext(ext), .edge_sel(esel),
    .clr_sel(c1), .sync_en(sen1), .buf_c(1'b0), .buf_d(1'b0),
    .reg_a(a1), .reg_b(b1), .reg_c(cc1), .reg_d(d1), .sync_clr_in(so0),
    .count(cnt1), .match(m1), .sync_clr_out(so1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1; src = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic step();
    seen0 = 0; seen1 = 0; pulses = 0;
    src = ~src;
    repeat (4) begin
      @(negedge clk);
      seen0 |= m0; seen1 |= m1; pulses += so0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", cnt0, 0);
    chk("R1 match", m0, 0);
    chk("R1 sync out", so0, 0);
  endtask

  task automatic t_internal();
    c0 = 3'b000; ext = 0; do_reset();
    esel = 2'b01; step(); chk("R2 rise counted", cnt0, 1);
    step(); chk("R2 fall ignored", cnt0, 1);
    esel = 2'b00; step(); chk("R2 rise ignored", cnt0, 1);
    step(); chk("R2 fall counted", cnt0, 2);
    esel = 2'b11; step(); step(); chk("R2 both edges", cnt0, 4);
  endtask

  task automatic t_external();
    ext = 1; do_reset();
    esel = 2'b00; step(); chk("R3 rise counted", cnt0, 1);
    step(); chk("R3 fall ignored", cnt0, 1);
    esel = 2'b01; step(); chk("R3 rise ignored", cnt0, 1);
    step(); chk("R3 fall counted", cnt0, 2);
    esel = 2'b10; step(); step(); chk("R3 both edges", cnt0, 4);
    ext = 0;
  endtask

  task automatic t_wrap();
    esel = 2'b10; c0 = 3'b100; a0 = 8'd5; do_reset();
    for (int i = 0; i < 255; i++) step();
    chk("R4 reaches max", cnt0, 255);
    step(); chk("R4 wraps", cnt0, 0);
    a0 = 8'd200;
  endtask

  task automatic t_clear_a();
    c0 = 3'b001; a0 = 8'd3; do_reset();
    step(); step(); step(); chk("R5 at A", cnt0, 3);
    step();
    chk("R5 cleared", cnt0, 0);
    chk("R12 match A pulse", seen0[0], 1);
    chk("R10 one pulse", pulses, 1);
    a0 = 8'd200;
  endtask

  task automatic t_clear_b();
    c0 = 3'b010; b0 = 8'd2; a0 = 8'd1; do_reset();
    step();
    chk("R12 match A without clear", seen0[0], 0);
    step();
    chk("R12 match A unselected", seen0[0], 1);
    chk("R6 no clear on A", cnt0, 2);
    step(); chk("R6 cleared on B", cnt0, 0);
    chk("R12 match B", seen0[1], 1);
    a0 = 8'd200; b0 = 8'd200;
  endtask

  task automatic t_clear_cd();
    c0 = 3'b101; cc0 = 8'd2; do_reset();
    step(); step(); step(); chk("R7 cleared on C", cnt0, 0);
    c0 = 3'b110; d0 = 8'd1; do_reset();
    step(); step(); chk("R7 cleared on D", cnt0, 0);
    chk("R12 match D", seen0[3], 1);
  endtask

  task automatic t_buffer();
    c0 = 3'b101; cc0 = 8'd2; bc = 1; do_reset();
    step(); step(); step();
    chk("R8 C buffered continues", cnt0, 3);
    chk("R8 C buffered no match", seen0[2], 0);
    c0 = 3'b110; d0 = 8'd1; bd = 1; do_reset();
    step(); step(); chk("R8 D buffered continues", cnt0, 2);
    bc = 0; bd = 0; cc0 = 8'd200; d0 = 8'd200;
  endtask

  task automatic t_sync();
    c0 = 3'b001; a0 = 8'd2; c1 = 3'b011; sen1 = 1; do_reset();
    step(); step(); step();
    chk("R9 receiver cleared", cnt1, 0);
    chk("R10 sender cleared same sample", cnt0, 0);
    chk("R10 single pulse", pulses, 1);
    sen1 = 0; do_reset();
    step(); step(); step();
    chk("R9 sync disabled ignored", cnt1, 3);
  endtask

  task automatic t_reduced();
    c0 = 3'b001; a0 = 8'd1; c1 = 3'b101; cc1 = 8'd1; d1 = 8'd1; sen1 = 1;
    do_reset();
    step(); step(); step();
    chk("R11 code 101 no clear", cnt1, 3);
    chk("R11 match C/D idle", int'(seen1[3:2]), 0);
    c1 = 3'b111; do_reset();
    step(); step(); step();
    chk("R11 code 111 no group clear", cnt1, 3);
    sen1 = 0; c1 = 3'b000;
  endtask

  initial begin
    t_reset();
    t_internal();
    t_external();
    t_wrap();
    t_clear_a();
    t_clear_b();
    t_clear_cd();
    t_buffer();
    t_sync();
    t_reduced();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule